// File: doc/BRIEF.md
# Bus Target Data-Phase Controller

This block is the target side of a shared parallel bus of the PCI kind. It samples the cycle-frame and command/byte-enable lines every clock, notices the clock on which a new transaction begins, and decodes the captured address and command one clock later. When the address falls inside a power-of-two window and the command is a memory read or a memory write, it claims the transaction by driving its device-select line. It then paces each data phase with its target-ready line against the initiator's ready line. When it cannot serve the transaction, it ends it with its stop line. Every bus line the block can drive comes with an output-enable, so the pads stay outside the block.

Toward the local side the block offers one request channel. `loc_req` is high while the target waits for the local side to serve the current phase. The local side answers with `loc_ack` (serve) or `loc_abort` (give up). Holding both low is back-pressure, and the request then stays up. For a read, `loc_rdata` must be valid in the same clock as `loc_ack`. A write beat is delivered through the one-clock strobe `loc_xfer`, together with `loc_wdata`, `loc_be` and `loc_addr`. The local side has no way to refuse a beat once it has acknowledged the phase.

Top module: `pcit_target`

## Requirements
- R1: The block captures address and command on the first clock edge at which `frame_n` is sampled low after being high. After that edge it does not yet drive `devsel_n`. After the next edge, `devsel_oe` is 1 and `devsel_n` is 0 (medium-speed claim).
- R2: A transaction is claimed only if the address bits above `WIN_LOG2` equal those of `WIN_BASE`, and the command on `cbe_n` during the address clock is 4'b0110 (memory read) or 4'b0111 (memory write). Any other transaction leaves all output-enables at 0 and `loc_req` at 0.
- R3: A data phase completes only on a clock where `irdy_n` and `trdy_n` are both low. `loc_xfer` is 1 exactly in those clocks. Once `trdy_n` is low, it stays low until the phase completes.
- R4: A phase that completes while `frame_n` is high is the last one. In the next clock, `devsel_n`, `trdy_n` and `stop_n` are driven high with their enables still 1. One clock later, every enable is 0.
- R5: `trdy_n` goes low in the clock after an edge at which `loc_req` and `loc_ack` were both high. For a read, `ad_out` then holds the `loc_rdata` taken at that edge, and `ad_oe` is 1 during the data phases.
- R6: For a write, the completing clock presents `loc_we`=1, `loc_wdata` equal to `ad_in`, and `loc_be` equal to the inverse of `cbe_n`. `ad_oe` stays 0.
- R7: If the first data phase sees `loc_req` high without `loc_ack` for `RETRY_LIMIT` (8) consecutive clocks, the target drives `stop_n` low with `trdy_n` high (retry). Seven such clocks followed by an ack give no retry.
- R8: `loc_abort` while `loc_req` is high drives `stop_n` low with `trdy_n` high in the next clock, in the first or any later phase. A stopped transaction ends at the first edge where `frame_n` is sampled high, followed by the same release sequence as R4.
- R9: While `rst_n` is low (asynchronously), every output-enable is 0 and `devsel_n`, `trdy_n`, `stop_n` read 1.
- R10: `loc_addr` equals the captured address with its two low bits cleared, plus 4 for each data phase already completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| frame_n | input | 1 | Cycle frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data lines as sampled |
| cbe_n | input | 4 | Command (address clock) or inverted byte enables (data clocks) |
| ad_out | output | 32 | Read data driven onto the address/data lines |
| ad_oe | output | 1 | Output enable for `ad_out` |
| devsel_n | output | 1 | Device select, active low |
| devsel_oe | output | 1 | Output enable for `devsel_n` |
| trdy_n | output | 1 | Target ready, active low |
| trdy_oe | output | 1 | Output enable for `trdy_n` |
| stop_n | output | 1 | Stop request, active low |
| stop_oe | output | 1 | Output enable for `stop_n` |
| loc_req | output | 1 | Local side asked to serve the current phase |
| loc_ack | input | 1 | Local side serves the phase (read data valid) |
| loc_abort | input | 1 | Local side gives up the transaction |
| loc_rdata | input | 32 | Read data from the local side |
| loc_we | output | 1 | Current transaction is a write |
| loc_addr | output | 32 | Word-aligned address of the current phase |
| loc_xfer | output | 1 | Data phase completes in this clock |
| loc_wdata | output | 32 | Write data of the completing phase |
| loc_be | output | 4 | Active-high byte enables of the completing phase |

## Verification
The bench sweeps burst length, local ack latency and initiator ready latency, for both reads and writes. A design that completed a phase on target-ready alone, or that missed the last phase, would show a wrong `loc_xfer` count or miss the release sequence. It also walks all sixteen commands and the addresses just inside and just outside the window, which catches a decode that claims a wrong command or treats the window edge one word off. The retry window is tested at exactly seven and eight not-ready clocks, so a timer that is off by one fires early or late. A reset in the middle of a transaction checks that the enables drop without waiting for a clock.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_DATA   = 2'd2,
    ST_TURN   = 2'd3
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pcit_decode.sv
module pcit_decode #(
  parameter int          WIN_LOG2 = 12,
  parameter logic [31:0] WIN_BASE = 32'h4000_0000,
  localparam int         TAG_W    = 32 - WIN_LOG2
) (
  input  logic [TAG_W-1:0] addr_tag,
  input  logic [3:0]       cmd,
  output logic             claim,
  output logic             is_write
);
  import pcit_pkg::*;

  localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[31:WIN_LOG2];

  logic in_window;
  logic cmd_ok;

  always_comb begin
    in_window = (addr_tag == BASE_TAG);
    cmd_ok    = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
    claim     = in_window && cmd_ok;
    is_write  = (cmd == CMD_MEM_WR);
  end

endmodule

// File: rtl/pcit_wait_timer.sv
module pcit_wait_timer #(
  parameter  int LIMIT = 8,
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  assign at_top = (cnt_q == CNT_W'(LIMIT - 1));
  assign expire = inc && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!inc || at_top) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7
  wait_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !at_top) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pcit_addr_ctr.sv
module pcit_addr_ctr #(
  parameter  int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              step,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (load) begin
      word <= load_word;
    end else if (step) begin
      word <= word + 1'b1;
    end
  end

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (word == $past(word) + 1'b1));

endmodule

// File: rtl/pcit_target.sv
module pcit_target #(
  parameter int          WIN_LOG2    = 12,
  parameter logic [31:0] WIN_BASE    = 32'h4000_0000,
  parameter int          RETRY_LIMIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        devsel_oe,
  output logic        trdy_n,
  output logic        trdy_oe,
  output logic        stop_n,
  output logic        stop_oe,
  output logic        loc_req,
  input  logic        loc_ack,
  input  logic        loc_abort,
  input  logic [31:0] loc_rdata,
  output logic        loc_we,
  output logic [31:0] loc_addr,
  output logic        loc_xfer,
  output logic [31:0] loc_wdata,
  output logic [3:0]  loc_be
);
  import pcit_pkg::*;

  localparam int WORD_W = 30;

  tgt_state_e  state_q;
  logic        frame_q;
  logic [31:2] addr_q;
  logic [3:0]  cmd_q;
  logic        we_q;
  logic        first_q;

  logic        start_seen;
  logic        claim;
  logic        dec_write;
  logic        tmr_inc;
  logic        tmr_expire;
  logic [WORD_W-1:0] cur_word;

  assign start_seen = (state_q == ST_IDLE) && !frame_n && frame_q;
  assign loc_req    = (state_q == ST_DATA) && trdy_n && stop_n;
  assign loc_xfer   = (state_q == ST_DATA) && !trdy_n && !irdy_n;
  assign tmr_inc    = loc_req && !loc_ack && !loc_abort && first_q;

  assign loc_we    = we_q;
  assign loc_addr  = {cur_word, 2'b00};
  assign loc_wdata = ad_in;
  assign loc_be    = ~cbe_n;

  pcit_decode #(
    .WIN_LOG2 (WIN_LOG2),
    .WIN_BASE (WIN_BASE)
  ) u_decode (
    .addr_tag (addr_q[31:WIN_LOG2]),
    .cmd      (cmd_q),
    .claim    (claim),
    .is_write (dec_write)
  );

  pcit_wait_timer #(
    .LIMIT (RETRY_LIMIT)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (tmr_inc),
    .expire (tmr_expire)
  );

  pcit_addr_ctr #(
    .WORD_W (WORD_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (state_q == ST_DECODE),
    .load_word (addr_q),
    .step      (loc_xfer),
    .word      (cur_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      frame_q   <= 1'b1;
      addr_q    <= '0;
      cmd_q     <= '0;
      we_q      <= 1'b0;
      first_q   <= 1'b0;
      devsel_n  <= 1'b1;
      trdy_n    <= 1'b1;
      stop_n    <= 1'b1;
      devsel_oe <= 1'b0;
      trdy_oe   <= 1'b0;
      stop_oe   <= 1'b0;
      ad_oe     <= 1'b0;
      ad_out    <= '0;
    end else begin
      frame_q <= frame_n;
      unique case (state_q)
        ST_IDLE: begin
          if (start_seen) begin
            addr_q  <= ad_in[31:2];
            cmd_q   <= cbe_n;
            state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (claim) begin
            state_q   <= ST_DATA;
            devsel_n  <= 1'b0;
            trdy_n    <= 1'b1;
            stop_n    <= 1'b1;
            devsel_oe <= 1'b1;
            trdy_oe   <= 1'b1;
            stop_oe   <= 1'b1;
            ad_oe     <= !dec_write;
            we_q      <= dec_write;
            first_q   <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (!stop_n) begin
            if (frame_n) begin
              state_q  <= ST_TURN;
              devsel_n <= 1'b1;
              stop_n   <= 1'b1;
              trdy_n   <= 1'b1;
              ad_oe    <= 1'b0;
            end
          end else if (loc_xfer) begin
            first_q <= 1'b0;
            trdy_n  <= 1'b1;
            if (frame_n) begin
              state_q  <= ST_TURN;
              devsel_n <= 1'b1;
              ad_oe    <= 1'b0;
            end
          end else if (loc_req) begin
            if (loc_ack) begin
              trdy_n <= 1'b0;
              ad_out <= loc_rdata;
            end else if (loc_abort || tmr_expire) begin
              stop_n <= 1'b0;
            end
          end
        end
        ST_TURN: begin
          state_q   <= ST_IDLE;
          devsel_oe <= 1'b0;
          trdy_oe   <= 1'b0;
          stop_oe   <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  claim_medium_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_oe) |-> (!devsel_n && !$past(frame_n, 2)));

  // R2
  claim_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_oe) |-> ($past(cbe_n, 2) == CMD_MEM_RD || $past(cbe_n, 2) == CMD_MEM_WR));

  // R3
  trdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !trdy_n && irdy_n) |=> !trdy_n);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_oe) |-> ($past(devsel_n) && $past(trdy_n) && $past(stop_n)));

  // R5
  trdy_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> $past(loc_req && loc_ack));

  // R7
  retry_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_n) |-> (trdy_n && stop_oe && !devsel_n));

  // R9
  reset_float_chk: assert property (@(posedge clk)
    !rst_n |-> (!devsel_oe && !trdy_oe && !stop_oe && !ad_oe));

endmodule

// File: tb/sim_pcit_target.sv
module sim_pcit_target;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [31:0] KEY  = 32'h5A3C_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n;
  logic [31:0] ad_in;
  logic [3:0]  cbe_n;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, devsel_oe, trdy_n, trdy_oe, stop_n, stop_oe;
  logic        loc_req, loc_ack, loc_abort;
  logic [31:0] loc_rdata;
  logic        loc_we, loc_xfer;
  logic [31:0] loc_addr, loc_wdata;
  logic [3:0]  loc_be;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcit_target #(.WIN_LOG2(12), .WIN_BASE(BASE), .RETRY_LIMIT(8)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_in(ad_in), .cbe_n(cbe_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .devsel_oe(devsel_oe), .trdy_n(trdy_n),
    .trdy_oe(trdy_oe), .stop_n(stop_n), .stop_oe(stop_oe),
    .loc_req(loc_req), .loc_ack(loc_ack), .loc_abort(loc_abort),
    .loc_rdata(loc_rdata), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_xfer(loc_xfer), .loc_wdata(loc_wdata), .loc_be(loc_be));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    frame_n = 1'b1; irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
    loc_ack = 1'b0; loc_abort = 1'b0; loc_rdata = '0;
  endtask

  task automatic check_released(input string req);
    chk(!devsel_oe && !trdy_oe && !stop_oe && !ad_oe, req,
        {28'd0, devsel_oe, trdy_oe, stop_oe, ad_oe}, 32'd0);
  endtask

  // address clock, then the R1 check that nothing is driven yet
  task automatic addr_phase(input logic [31:0] addr, input logic [3:0] cmd);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(posedge clk);
    @(negedge clk);
    chk(!devsel_oe, "R1 no claim right after address clock", {31'd0, devsel_oe}, 32'd0);
    ad_in = '0; cbe_n = 4'h0;
    @(posedge clk);
  endtask

  task automatic end_sequence(input string req);
    @(negedge clk);
    chk(devsel_oe && trdy_oe && stop_oe && devsel_n && trdy_n && stop_n, req,
        {26'd0, devsel_oe, trdy_oe, stop_oe, devsel_n, trdy_n, stop_n}, 32'h3F);
    irdy_n = 1'b1; frame_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_released(req);
  endtask

  task automatic run_burst(input logic [31:0] addr, input bit we, input int nph,
                           input int ackd, input int irdyd);
    logic [31:0] wbase;
    wbase = {addr[31:2], 2'b00};
    addr_phase(addr, we ? 4'b0111 : 4'b0110);
    for (int p = 0; p < nph; p++) begin
      int  cyc = 0;
      int  w   = 0;
      bit  done = 0;
      while (!done && cyc < 40) begin
        logic [31:0] wd;
        logic [3:0]  cb;
        @(negedge clk);
        if (p == 0 && cyc == 0)
          chk(devsel_oe && !devsel_n, "R1 claim one clock after decode",
              {30'd0, devsel_oe, devsel_n}, 32'd2);
        wd = 32'hC0DE_0000 + 32'(p) * 32'h111 + addr[11:0];
        cb = 4'(p) ^ 4'hA;
        irdy_n    = (cyc < irdyd);
        frame_n   = (p == nph - 1 && !irdy_n);
        ad_in     = we ? wd : 32'h0;
        cbe_n     = we ? cb : 4'h0;
        loc_rdata = KEY ^ (wbase + 32'(4 * p));
        loc_ack   = loc_req && (w >= ackd);
        if (loc_req) w++;
        #1;
        if (!irdy_n && !trdy_n) begin
          done = 1;
          chk(loc_xfer, "R3 completion on joint ready", {31'd0, loc_xfer}, 32'd1);
          chk(loc_addr == wbase + 32'(4 * p), "R10 phase address", loc_addr, wbase + 32'(4 * p));
          if (we) begin
            chk(loc_we && loc_wdata == wd && !ad_oe, "R6 write data", loc_wdata, wd);
            chk(loc_be == ~cb, "R6 byte enables", {28'd0, loc_be}, {28'd0, ~cb});
          end else begin
            chk(ad_oe && ad_out == (KEY ^ (wbase + 32'(4 * p))), "R5 read data on bus",
                ad_out, KEY ^ (wbase + 32'(4 * p)));
          end
        end else begin
          chk(!loc_xfer, "R3 no completion without joint ready", {31'd0, loc_xfer}, 32'd0);
          chk(stop_n, "R7 no retry under limit", {31'd0, stop_n}, 32'd1);
        end
        cyc++;
        @(posedge clk);
      end
      loc_ack = 1'b0;
    end
    end_sequence("R4 final phase release");
    bus_idle();
  endtask

  task automatic run_miss(input logic [31:0] addr, input logic [3:0] cmd);
    addr_phase(addr, cmd);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      frame_n = (c >= 2); irdy_n = (c < 1);
      #1;
      chk(!devsel_oe && !trdy_oe && !stop_oe && !loc_req, "R2 not claimed",
          {28'd0, devsel_oe, trdy_oe, stop_oe, loc_req}, 32'd0);
      @(posedge clk);
    end
    @(negedge clk);
    bus_idle();
  endtask

  // mode 0: timeout retry, mode 1: abort first phase, mode 2: abort second phase
  task automatic run_stop(input logic [31:0] addr, input bit we, input int mode);
    int reqc = 0;
    int cyc  = 0;
    addr_phase(addr, we ? 4'b0111 : 4'b0110);
    if (mode == 2) begin
      bit done = 0;
      while (!done && cyc < 10) begin
        @(negedge clk);
        irdy_n = 1'b0; frame_n = 1'b0; loc_ack = loc_req;
        #1;
        done = loc_xfer;
        cyc++;
        @(posedge clk);
      end
      loc_ack = 1'b0;
      cyc = 0;
    end
    forever begin
      @(negedge clk);
      if (!stop_n || cyc > 20) break;
      if (loc_req) reqc++;
      irdy_n = 1'b0; frame_n = 1'b0; loc_ack = 1'b0;
      loc_abort = (mode != 0) && loc_req;
      #1;
      chk(!loc_xfer, mode == 0 ? "R7 no data during wait" : "R8 no data during abort",
          {31'd0, loc_xfer}, 32'd0);
      cyc++;
      @(posedge clk);
    end
    loc_abort = 1'b0;
    chk(!stop_n && trdy_n && stop_oe && !devsel_n, mode == 0 ? "R7 retry shape" : "R8 stop shape",
        {28'd0, stop_n, trdy_n, stop_oe, devsel_n}, 32'h6);
    if (mode == 0)
      chk(reqc == 8, "R7 retry after eight not-ready clocks", 32'(reqc), 32'd8);
    else
      chk(reqc == 1, "R8 stop one clock after abort", 32'(reqc), 32'd1);
    frame_n = 1'b1; irdy_n = 1'b0;
    #1;
    chk(!loc_req && !loc_xfer, "R8 no request while stopping", {30'd0, loc_req, loc_xfer}, 32'd0);
    @(posedge clk);
    end_sequence("R8 stopped transaction release");
    bus_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R3 run did not end actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bus_idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_released("R9 reset floats outputs");
    chk(devsel_n && trdy_n && stop_n, "R9 reset values", {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep of burst shapes
    for (int we = 0; we < 2; we++)
      for (int n = 1; n <= 4; n++)
        for (int a = 0; a < 4; a++)
          for (int d = 0; d < 2; d++) begin
            int ackd = (a == 3) ? 7 : a;
            logic [31:0] ad = BASE + 32'(((we * 16 + n * 4 + a) * 2 + d) * 20) + 32'(a);
            run_burst(ad, we[0], n, ackd, d * 2);
          end

    // window edges
    run_burst(BASE + 32'hFFC, 1'b0, 1, 0, 0);
    run_burst(BASE, 1'b1, 2, 1, 1);
    run_miss(BASE + 32'h1000, 4'b0110);
    run_miss(BASE - 32'd4, 4'b0111);

    // every other command at a hit address
    for (int c = 0; c < 16; c++)
      if (c != 6 && c != 7) run_miss(BASE + 32'h40, 4'(c));

    // retry and abort
    run_stop(BASE + 32'h80, 1'b0, 0);
    run_stop(BASE + 32'h84, 1'b1, 0);
    run_stop(BASE + 32'h88, 1'b0, 1);
    run_stop(BASE + 32'h8C, 1'b1, 2);

    // back to normal after a stop
    run_burst(BASE + 32'h100, 1'b0, 3, 2, 0);

    // reset in the middle of a claimed transaction
    addr_phase(BASE + 32'h200, 4'b0110);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_released("R9 asynchronous float");
    chk(devsel_n && trdy_n && stop_n, "R9 asynchronous values", {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
    bus_idle();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_burst(BASE + 32'h204, 1'b1, 1, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule